// File: doc/BRIEF.md
# Dual-Port Collision Arbiter with Write Inhibit

This block sits beside a two-port memory array and watches the chip enable and address of each port. When both ports are enabled on the same address in the same cycle, it lets one of them through and flags the other as busy. Any write from the flagged port is masked before it reaches the array. Arbitration uses only the enables and addresses. Whether an access is a read or a write plays no part in it.

A mode pin picks the role. In master mode the block arbitrates and drives active-low busy indications. Each indication is a value and output-enable pair, so a wired-AND or an OR of several parts can be built outside. In slave mode the block does no arbitration. It releases its busy drivers, and each port's busy input, active low, acts only as a write inhibit for that port. A master placed next to one or more slaves makes the decision once for a whole wide word.

The model has one cycle of settling. Address and enable are registered in one cycle, and busy is valid from the next cycle. The write strobe is sampled in that next cycle and gated with the settled busy. This is why the address must be held for two cycles around a write. The block has no data path, so every pin is a plain control signal with no valid/ready handshake.

Top module: `dpb_busy_arbiter`

## Requirements
- R1: During and directly after reset, both busy values are high (inactive) and no gated write enable is asserted unless its port's enable and write request are both high.
- R2: In master mode, if both enables are high and the addresses are equal at a clock edge, exactly one busy value is low after that edge. If the enables and addresses do not collide at the edge, both busy values are high after it.
- R3: In master mode, if neither port held its address in the previous cycle (held means enabled with the same address), a collision grants the left port, and the right busy value goes low.
- R4: In master mode, if exactly one port held the colliding address in the previous cycle, that port keeps it, and the newcomer's busy value goes low. If both held it, the busy side from the previous cycle is kept.
- R5: The write requests have no effect on which busy value goes low.
- R6: A gated write enable is high only when its port's enable and write request are high and that port is not inhibited. In master mode a port is inhibited when its own busy value is low.
- R7: Busy returns high in the cycle after the collision condition ends (an enable drops or the addresses differ).
- R8: In slave mode both busy output enables are low, both busy values are high, and a low busy input blocks all writes from its port. A high busy input allows normal writes.
- R9: In master mode both busy output enables are high, and the busy inputs have no effect on the gated write enables.
- R10: At no time are both busy values low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1 = arbitrate and drive busy, 0 = slave, busy inputs only inhibit writes |
| l_en | input | 1 | Left port chip enable, active high |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port chip enable, active high |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left external busy, active low, used as a write inhibit in slave mode |
| r_busy_in_n | input | 1 | Right external busy, active low, used as a write inhibit in slave mode |
| l_busy_val_n | output | 1 | Left busy value, active low |
| l_busy_oe | output | 1 | Left busy driver enable (high in master mode) |
| r_busy_val_n | output | 1 | Right busy value, active low |
| r_busy_oe | output | 1 | Right busy driver enable (high in master mode) |
| l_we | output | 1 | Gated left write enable to the array |
| r_we | output | 1 | Gated right write enable to the array |

## Verification
The assertions check these rules on every cycle:
- At most one busy value is low.
- A collision in master mode always produces a busy one edge later.
- Busy clears one edge after the collision ends.
- A gated write never escapes its inhibit in either mode.
- The busy drivers are released in slave mode.

Only the bench scenarios show which side wins, because that depends on who held the address before. They also show the priority given to the left port when both start together, that the busy choice is the same for reads and writes, and that the busy inputs are ignored in master mode.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int unsigned NPORTS = 2;
  localparam int unsigned PL     = 0;
  localparam int unsigned PR     = 1;

  typedef enum logic [1:0] {
    GRANT_NONE  = 2'b00,
    GRANT_LEFT  = 2'b01,
    GRANT_RIGHT = 2'b10
  } grant_e;
endpackage

// File: rtl/dpb_hold_track.sv
module dpb_hold_track #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hold
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  // the port already owned this address in the previous cycle
  assign hold = en && prev_en && (addr == prev_addr);
endmodule

// File: rtl/dpb_arbiter.sv
module dpb_arbiter #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_hold,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_hold,
  output logic              busy_l_q,
  output logic              busy_r_q
);
  import dpb_pkg::*;

  logic   collide;
  grant_e grant_d;

  assign collide = is_master && l_en && r_en && (l_addr == r_addr);

  always_comb begin
    grant_d = GRANT_NONE;
    if (collide) begin
      if (l_hold && !r_hold)      grant_d = GRANT_LEFT;
      else if (r_hold && !l_hold) grant_d = GRANT_RIGHT;
      else if (l_hold && r_hold && busy_l_q) grant_d = GRANT_RIGHT;
      else                        grant_d = GRANT_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_l_q <= 1'b0;
      busy_r_q <= 1'b0;
    end else begin
      busy_l_q <= (grant_d == GRANT_RIGHT);
      busy_r_q <= (grant_d == GRANT_LEFT);
    end
  end
endmodule

// File: rtl/dpb_wr_gate.sv
module dpb_wr_gate (
  input  logic is_master,
  input  logic en,
  input  logic wr,
  input  logic busy_own_q,
  input  logic busy_in_n,
  output logic we
);
  logic inhibit;

  assign inhibit = is_master ? busy_own_q : !busy_in_n;
  assign we      = en && wr && !inhibit;
endmodule

// File: rtl/dpb_busy_arbiter.sv
module dpb_busy_arbiter #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_val_n,
  output logic              l_busy_oe,
  output logic              r_busy_val_n,
  output logic              r_busy_oe,
  output logic              l_we,
  output logic              r_we
);
  import dpb_pkg::*;

  logic [NPORTS-1:0]             en_a, wr_a, hold_a, busy_q_a, bin_a, we_a;
  logic [NPORTS-1:0][ADDR_W-1:0] addr_a;

  assign en_a[PL]   = l_en;        assign en_a[PR]   = r_en;
  assign wr_a[PL]   = l_wr;        assign wr_a[PR]   = r_wr;
  assign addr_a[PL] = l_addr;      assign addr_a[PR] = r_addr;
  assign bin_a[PL]  = l_busy_in_n; assign bin_a[PR]  = r_busy_in_n;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpb_hold_track #(.ADDR_W(ADDR_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_a[p]),
      .addr  (addr_a[p]),
      .hold  (hold_a[p])
    );
    dpb_wr_gate u_gate (
      .is_master  (is_master),
      .en         (en_a[p]),
      .wr         (wr_a[p]),
      .busy_own_q (busy_q_a[p]),
      .busy_in_n  (bin_a[p]),
      .we         (we_a[p])
    );
  end

  dpb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_master (is_master),
    .l_en      (l_en),
    .l_addr    (l_addr),
    .l_hold    (hold_a[PL]),
    .r_en      (r_en),
    .r_addr    (r_addr),
    .r_hold    (hold_a[PR]),
    .busy_l_q  (busy_q_a[PL]),
    .busy_r_q  (busy_q_a[PR])
  );

  assign l_busy_val_n = !busy_q_a[PL];
  assign r_busy_val_n = !busy_q_a[PR];
  assign l_busy_oe    = is_master;
  assign r_busy_oe    = is_master;
  assign l_we         = we_a[PL];
  assign r_we         = we_a[PR];
endmodule

// File: rtl/dpb_busy_arbiter_chk.sv
module dpb_busy_arbiter_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_master,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_wr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_wr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_val_n,
  input logic              l_busy_oe,
  input logic              r_busy_val_n,
  input logic              r_busy_oe,
  input logic              l_we,
  input logic              r_we
);
  logic coll;
  assign coll = l_en && r_en && (l_addr == r_addr);

  p_one_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_val_n && !r_busy_val_n));

  p_coll_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && coll) |=> !(l_busy_val_n && r_busy_val_n));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !coll |=> (l_busy_val_n && r_busy_val_n));

  p_we_gate_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    l_we |-> (l_en && l_wr && !(is_master && !l_busy_val_n)));

  p_we_gate_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    r_we |-> (r_en && r_wr && !(is_master && !r_busy_val_n)));

  p_slave_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!l_busy_oe && !r_busy_oe));

  p_slave_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && (!l_busy_in_n || !r_busy_in_n)) |->
      !((!l_busy_in_n && l_we) || (!r_busy_in_n && r_we)));

  p_master_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> (l_busy_oe && r_busy_oe));
endmodule

bind dpb_busy_arbiter dpb_busy_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_master(is_master),
  .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
  .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
  .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
  .l_busy_val_n(l_busy_val_n), .l_busy_oe(l_busy_oe),
  .r_busy_val_n(r_busy_val_n), .r_busy_oe(r_busy_oe),
  .l_we(l_we), .r_we(r_we)
);

// File: tb/dpb_busy_arbiter_tb.sv
module dpb_busy_arbiter_tb;
  localparam int unsigned AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master, l_en, l_wr, r_en, r_wr, l_busy_in_n, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_busy_val_n, l_busy_oe, r_busy_val_n, r_busy_oe, l_we, r_we;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  dpb_busy_arbiter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_val_n(l_busy_val_n), .l_busy_oe(l_busy_oe),
    .r_busy_val_n(r_busy_val_n), .r_busy_oe(r_busy_oe),
    .l_we(l_we), .r_we(r_we)
  );

  typedef struct packed {
    logic       m;
    logic       le;
    logic [3:0] la;
    logic       lw;
    logic       re;
    logic [3:0] ra;
    logic       rw;
    logic       lbi;
    logic       rbi;
    logic       elb;
    logic       erb;
    logic       elw;
    logic       erw;
  } vec_t;

  localparam int NV = 18;
  // each row: inputs, then expected busy values and gated write enables one edge later
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // idle R2
    '{1'b1,1'b1,4'd5,1'b0,1'b1,4'd5,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0}, // both new: left wins R3
    '{1'b1,1'b1,4'd5,1'b1,1'b1,4'd5,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // keep, right write masked R4 R6
    '{1'b1,1'b1,4'd5,1'b1,1'b0,4'd5,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0}, // right drops: clear R7
    '{1'b1,1'b1,4'd5,1'b1,1'b1,4'd5,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // left holder keeps R4
    '{1'b1,1'b0,4'd5,1'b1,1'b1,4'd5,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b1}, // left drops R7
    '{1'b1,1'b1,4'd5,1'b0,1'b1,4'd5,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1}, // right holder keeps R4
    '{1'b1,1'b1,4'd5,1'b1,1'b1,4'd5,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1}, // both held, keep left busy R4 R6
    '{1'b1,1'b1,4'd6,1'b1,1'b1,4'd5,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // addresses differ R7
    '{1'b1,1'b1,4'd7,1'b0,1'b1,4'd7,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0}, // both moved: left wins R3
    '{1'b1,1'b0,4'd7,1'b0,1'b0,4'd7,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // idle R7
    '{1'b1,1'b1,4'd3,1'b1,1'b1,4'd3,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // writes, same choice R5
    '{1'b1,1'b0,4'd3,1'b0,1'b0,4'd3,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // idle
    '{1'b0,1'b1,4'd4,1'b1,1'b1,4'd4,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // slave, no arbitration R8
    '{1'b0,1'b1,4'd4,1'b1,1'b1,4'd4,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1}, // slave left inhibit R8
    '{1'b0,1'b1,4'd4,1'b1,1'b1,4'd4,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0}, // slave right inhibit R8
    '{1'b1,1'b1,4'd4,1'b1,1'b1,4'd4,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0}, // master ignores inputs R9
    '{1'b1,1'b0,4'd4,1'b0,1'b0,4'd4,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0}  // idle R9
  };

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t v);
    is_master = v.m; l_en = v.le; l_addr = AW'(v.la); l_wr = v.lw;
    r_en = v.re; r_addr = AW'(v.ra); r_wr = v.rw;
    l_busy_in_n = v.lbi; r_busy_in_n = v.rbi;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    drive('0);
    is_master = 1'b1; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(l_busy_val_n && r_busy_val_n && !l_we && !r_we, "R1 reset",
        {l_busy_val_n, r_busy_val_n, l_we, r_we}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(posedge clk);
      @(negedge clk);
      chk({l_busy_val_n, r_busy_val_n, l_we, r_we} == {TBL[i].elb, TBL[i].erb, TBL[i].elw, TBL[i].erw},
          $sformatf("R2-table row %0d", i),
          {l_busy_val_n, r_busy_val_n, l_we, r_we},
          {TBL[i].elb, TBL[i].erb, TBL[i].elw, TBL[i].erw});
      chk({l_busy_oe, r_busy_oe} == {TBL[i].m, TBL[i].m}, "R8 R9 driver enable",
          {2'b00, l_busy_oe, r_busy_oe}, {2'b00, TBL[i].m, TBL[i].m});
    end

    // R1: reset while busy is active clears it
    drive('{1'b1,1'b1,4'd9,1'b1,1'b1,4'd9,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0});
    @(posedge clk); @(negedge clk);
    chk(!r_busy_val_n, "R3 setup", {3'b000, r_busy_val_n}, 4'b0000);
    rst_n = 1'b0;
    #1;
    chk(l_busy_val_n && r_busy_val_n && l_we && r_we, "R1 reset while busy",
        {l_busy_val_n, r_busy_val_n, l_we, r_we}, 4'b1111);
    @(negedge clk);
    rst_n = 1'b1;
    // after reset both ports are new: left wins again
    @(posedge clk); @(negedge clk);
    chk(l_busy_val_n && !r_busy_val_n && l_we && !r_we, "R3 after reset",
        {l_busy_val_n, r_busy_val_n, l_we, r_we}, 4'b1010);

    // R5: read-only collision picks the same side as the write collision
    drive('{1'b1,1'b0,4'd0,1'b0,1'b0,4'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0});
    @(posedge clk); @(negedge clk);
    drive('{1'b1,1'b1,4'd2,1'b0,1'b1,4'd2,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0});
    @(posedge clk); @(negedge clk);
    chk(l_busy_val_n && !r_busy_val_n && !r_we, "R5 mixed read/write",
        {l_busy_val_n, r_busy_val_n, l_we, r_we}, 4'b1000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule